// File: doc/BRIEF.md
# Programmable Color Space Converter

This block converts a stream of three-channel video pixels from one color space to another. It applies a 3x3 weight matrix and then adds a per-row offset. Each of the three output channels is the signed weighted sum of all three input channels plus a constant. The sum is rounded, and the result is clamped back into the unsigned pixel range. Pixels enter with a valid flag. They leave after a fixed three-cycle pipeline, with a matching valid flag.

The block holds twelve 13-bit signed values: nine weights and three offsets. These are written one byte at a time through a small write port. A control byte holds an enable bit and a two-bit scale mode. The scale mode sets the real-number weight of a code, with full scale of ±1, ±2 or ±4. With the enable bit clear, pixels pass through untouched, with the same latency.

The reset contents form a video YCbCr-to-RGB matrix. The channel roles are: input 0 = Cr, input 1 = Y, input 2 = Cb.

Top module: `csc_matrix`

## Requirements
- R1: After reset, the enable bit is 0, the scale mode is 01 and the twelve values are (k = 0..11): 0x0C52, 0x0800, 0x0000, 0x19D7, 0x1C41, 0x0800, 0x1E81, 0x029F, 0x0000, 0x0800, 0x0ED8, 0x1894. While reset is applied, the outputs are 0 and the output valid is low.
- R2: Value k (0..11) sits at write addresses 2k and 2k+1. Address 2k takes bits 12:8 from data bits 4:0, and address 2k+1 takes bits 7:0. Value k is weight (row k/4, column k%4) for k%4 < 3, and the row offset for k%4 = 3. Rows are outputs 0, 1, 2.
- R3: Address 24 is the control byte: bit 0 is enable and bits 2:1 are the scale mode. Writes to addresses 25 to 31 change nothing.
- R4: When enabled, output row i equals W[i][0]*in0 + W[i][1]*in1 + W[i][2]*in2 + 256*O[i]. All values are 13-bit two's complement and the inputs are unsigned. This sum is multiplied by 2^m, with m = 0, 1 or 2 for modes 00, 01 and 1x. The result is floor((acc + 2048) / 4096).
- R5: A result below 0 gives 0, and a result above 255 gives 255.
- R6: Each pixel accepted with the input valid high appears with the output valid high exactly 3 clock edges later. While the output valid is low, the output data holds its last value.
- R7: When enable is 0, the outputs equal the inputs unchanged, with the same 3-cycle latency.
- R8: A write takes effect for pixels accepted on later edges. A pixel accepted on the same edge as a write, or already in the pipeline, uses the old values.
- R9: Scale mode 11 behaves exactly like mode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| vld_i | input | 1 | Input pixel valid |
| ch0_i | input | 8 | Input channel 0 |
| ch1_i | input | 8 | Input channel 1 |
| ch2_i | input | 8 | Input channel 2 |
| vld_o | output | 1 | Output pixel valid |
| ch0_o | output | 8 | Output channel 0 |
| ch1_o | output | 8 | Output channel 1 |
| ch2_o | output | 8 | Output channel 2 |

## Verification
A corrupted weight or offset register shows up on the very next affected pixel, three cycles after it is accepted. It appears as an output byte that differs from the arithmetic model for that row. The sweeps hit every weight with non-trivial input values, so any such corruption is caught. A wrong scale decode or rounding step moves results by whole LSBs across large parts of the sweep. A pipeline stage that loses or takes a config snapshot at the wrong time shows up on the pixel that shares an edge with a write. A broken valid delay misaligns the expected-value queue on the first pixel.

// File: rtl/csc_matrix.sv
module csc_matrix #(
  parameter int DW = 8,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          vld_i,
  input  logic [DW-1:0] ch0_i,
  input  logic [DW-1:0] ch1_i,
  input  logic [DW-1:0] ch2_i,
  output logic          vld_o,
  output logic [DW-1:0] ch0_o,
  output logic [DW-1:0] ch1_o,
  output logic [DW-1:0] ch2_o
);
  localparam int FR = 12;
  localparam int PW = CW + DW + 1;
  localparam int AW = PW + 5;
  localparam int NV = 12;
  localparam logic [4:0] CTRL = 5'd24;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FR - 1);
  localparam logic signed [AW-1:0] TOP  = AW'((1 << DW) - 1);
  localparam logic [CW-1:0] DEF [0:NV-1] = '{
    13'h0C52, 13'h0800, 13'h0000, 13'h19D7,
    13'h1C41, 13'h0800, 13'h1E81, 13'h029F,
    13'h0000, 13'h0800, 13'h0ED8, 13'h1894};

  logic [CW-1:0] cv [0:NV-1];
  logic          en_q;
  logic [1:0]    sc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NV; k++) cv[k] <= DEF[k];
      en_q <= 1'b0;
      sc_q <= 2'b01;
    end else if (cfg_we) begin
      if (cfg_addr == CTRL) begin
        en_q <= cfg_wdata[0];
        sc_q <= cfg_wdata[2:1];
      end else if (cfg_addr < CTRL) begin
        if (cfg_addr[0]) cv[cfg_addr[4:1]][7:0]    <= cfg_wdata;
        else             cv[cfg_addr[4:1]][CW-1:8] <= cfg_wdata[CW-9:0];
      end
    end
  end

  logic [DW-1:0] din [0:2];
  assign din[0] = ch0_i;
  assign din[1] = ch1_i;
  assign din[2] = ch2_i;

  logic                 v1, v2, e1, e2;
  logic [1:0]           s1;
  logic signed [PW-1:0] p1 [0:2][0:2];
  logic [CW-1:0]        o1 [0:2];
  logic [DW-1:0]        b1 [0:2], b2 [0:2];
  logic signed [AW-1:0] a2 [0:2];
  logic signed [AW-1:0] sum_c [0:2];
  logic [DW-1:0]        res_c [0:2];
  logic [DW-1:0]        dq [0:2];

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      sum_c[i] = AW'(p1[i][0]) + AW'(p1[i][1]) + AW'(p1[i][2])
               + ({{(AW-CW){o1[i][CW-1]}}, o1[i]} <<< 8);
      sum_c[i] = sum_c[i] <<< (s1[1] ? 2 : (s1[0] ? 1 : 0));
    end
  end

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      logic signed [AW-1:0] q;
      q = (a2[i] + HALF) >>> FR;
      if (!e2)          res_c[i] = b2[i];
      else if (q < 0)   res_c[i] = '0;
      else if (q > TOP) res_c[i] = '1;
      else              res_c[i] = q[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; vld_o <= 1'b0;
      e1 <= 1'b0; e2 <= 1'b0; s1 <= '0;
      for (int i = 0; i < 3; i++) begin
        o1[i] <= '0; b1[i] <= '0; b2[i] <= '0; a2[i] <= '0; dq[i] <= '0;
        for (int j = 0; j < 3; j++) p1[i][j] <= '0;
      end
    end else begin
      v1 <= vld_i; v2 <= v1; vld_o <= v2;
      if (vld_i) begin
        e1 <= en_q; s1 <= sc_q;
        for (int i = 0; i < 3; i++) begin
          o1[i] <= cv[4*i+3];
          b1[i] <= din[i];
          for (int j = 0; j < 3; j++)
            p1[i][j] <= $signed(cv[4*i+j]) * $signed({1'b0, din[j]});
        end
      end
      if (v1) begin
        e2 <= e1;
        for (int i = 0; i < 3; i++) begin
          a2[i] <= sum_c[i];
          b2[i] <= b1[i];
        end
      end
      if (v2)
        for (int i = 0; i < 3; i++) dq[i] <= res_c[i];
    end
  end

  assign ch0_o = dq[0];
  assign ch1_o = dq[1];
  assign ch2_o = dq[2];

  logic [1:0] live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= '0;
    else if (live != 2'd3) live <= live + 2'd1;

  a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 2'd3) |-> (vld_o == $past(vld_i, 3)));

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (live != 2'd0 && !vld_o) |-> ($stable(ch0_o) && $stable(ch1_o) && $stable(ch2_o)));

  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 2'd3 && vld_o && !$past(en_q, 3)) |->
      (ch0_o == $past(ch0_i, 3) && ch1_o == $past(ch1_i, 3) && ch2_o == $past(ch2_i, 3)));

  a_r3_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CTRL) |=> ({sc_q, en_q} == $past(cfg_wdata[2:0])));

  a_r3_high_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr > CTRL) |=> ($stable(en_q) && $stable(sc_q)));
endmodule

// File: tb/sim_csc_matrix.sv
module sim_csc_matrix;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic vld_i = 1'b0;
  logic [7:0] ch0_i = '0, ch1_i = '0, ch2_i = '0;
  logic vld_o;
  logic [7:0] ch0_o, ch1_o, ch2_o;

  always #4 clk = ~clk;

  csc_matrix u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .vld_i(vld_i), .ch0_i(ch0_i), .ch1_i(ch1_i), .ch2_i(ch2_i),
    .vld_o(vld_o), .ch0_o(ch0_o), .ch1_o(ch1_o), .ch2_o(ch2_o));

  int total = 0, bad = 0;
  int mc [12] = '{'h0C52, 'h0800, 0, 'h19D7, 'h1C41, 'h0800, 'h1E81, 'h029F,
                  0, 'h0800, 'h0ED8, 'h1894};
  int men = 0, mmode = 1;
  logic [23:0] expq [$];
  string tag = "R4";
  logic [23:0] last_o = '0;
  bit seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= 4096) ? v - 8192 : v;
  endfunction

  function automatic int row(input int i, input int a, input int b, input int c);
    int m, acc, q;
    if (men == 0) return (i == 0) ? a : (i == 1) ? b : c;
    m = (mmode >= 2) ? 2 : mmode;
    acc = (sx(mc[4*i]) * a + sx(mc[4*i+1]) * b + sx(mc[4*i+2]) * c + sx(mc[4*i+3]) * 256) * (1 << m);
    q = (acc + 2048) >>> 12;
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    return q;
  endfunction

  task automatic step(input bit v, input int a, input int b, input int c,
                      input bit we, input int addr, input int data);
    @(negedge clk);
    vld_i = v; ch0_i = 8'(a); ch1_i = 8'(b); ch2_i = 8'(c);
    cfg_we = we; cfg_addr = 5'(addr); cfg_wdata = 8'(data);
    if (v) expq.push_back({8'(row(0, a, b, c)), 8'(row(1, a, b, c)), 8'(row(2, a, b, c))});
    if (we) begin
      if (addr == 24) begin men = data & 1; mmode = (data >> 1) & 3; end
      else if (addr < 24) begin
        if (addr % 2) mc[addr/2] = (mc[addr/2] & 'h1F00) | (data & 'hFF);
        else          mc[addr/2] = (mc[addr/2] & 'hFF) | ((data & 'h1F) << 8);
      end
    end
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(input int addr, input int data); step(0, 0, 0, 0, 1, addr, data); endtask
  task automatic setv(input int k, input int v);
    wr(2*k, (v >> 8) & 'h1F); wr(2*k+1, v & 'hFF);
  endtask
  task automatic drain(input string req);
    repeat (5) idle();
    chk(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic sweep(input int stp, input int gap);
    int n = 0;
    for (int a = 0; a < 256; a += stp)
      for (int b = 0; b < 256; b += stp)
        for (int c = 0; c < 256; c += stp) begin
          if (gap != 0 && n % gap == 3) idle();
          step(1, a, b, c, 0, 0, 0);
          n++;
        end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (vld_o) begin
        if (expq.size() == 0) chk(0, "R6", 1, 0);
        else begin
          logic [23:0] e;
          e = expq.pop_front();
          chk({ch0_o, ch1_o, ch2_o} == e, tag, {ch0_o, ch1_o, ch2_o}, e);
        end
        last_o = {ch0_o, ch1_o, ch2_o};
        seen = 1;
      end else if (seen) begin
        chk({ch0_o, ch1_o, ch2_o} == last_o, "R6 hold", {ch0_o, ch1_o, ch2_o}, last_o);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(vld_o == 0 && {ch0_o, ch1_o, ch2_o} == 0, "R1 reset", {vld_o, ch0_o, ch1_o, ch2_o}, 0);
    rst_n = 1'b1;

    tag = "R7 bypass default";
    sweep(51, 0);
    drain("R7");

    tag = "R6 latency";
    step(1, 10, 20, 30, 0, 0, 0);
    idle(); chk(vld_o == 0, "R6 edge1", vld_o, 0);
    idle(); chk(vld_o == 0, "R6 edge2", vld_o, 0);
    idle(); chk(vld_o == 1, "R6 edge3", vld_o, 1);
    drain("R6");

    tag = "R1 default matrix R4";
    wr(24, 3);
    sweep(17, 7);
    drain("R1");

    tag = "R2 R4 custom matrix";
    setv(0, 'h0700); setv(1, 'h1D00); setv(2, 'h0123); setv(3, 'h0040);
    setv(4, 'h1F80); setv(5, 'h0A00); setv(6, 'h0300); setv(7, 'h1FC0);
    setv(8, 'h0400); setv(9, 'h0055); setv(10, 'h1E00); setv(11, 'h0100);
    for (int md = 0; md < 4; md++) begin
      wr(24, (md << 1) | 1);
      tag = (md == 3) ? "R9 mode 11" : "R4 scale mode";
      sweep(37, 5);
    end
    drain("R4");

    tag = "R5 clamp";
    setv(0, 'h0FFF); setv(1, 0); setv(2, 0); setv(3, 'h0FFF);
    setv(4, 'h1000); setv(5, 0); setv(6, 0); setv(7, 'h1000);
    setv(8, 'h0100); setv(9, 'h0100); setv(10, 'h0100); setv(11, 0);
    wr(24, 5);
    sweep(29, 0);
    drain("R5");

    tag = "R3 ignored high addr";
    for (int ad = 25; ad < 32; ad++) wr(ad, 'hA5);
    sweep(64, 0);
    drain("R3");

    tag = "R8 write with pixel";
    wr(24, 3);
    for (int t = 0; t < 24; t++) begin
      step(1, 40 + t, 90, 200 - t, 1, t, t * 11 + 3);
      step(1, 120, 60 + t, 30, 0, 0, 0);
    end
    step(1, 77, 88, 99, 1, 24, 0);
    step(1, 77, 88, 99, 1, 24, 5);
    step(1, 77, 88, 99, 0, 0, 0);
    drain("R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule